// File: doc/BRIEF.md
# Fractional Saturating Multiplier

This block multiplies signed fractional operands in Q15 and Q31 format, and also forms small unsigned integer products. It can narrow a result to 16 or 8 bits, with or without rounding. A fractional product is the two's-complement product doubled, so that the binary point stays in place. The only product that cannot be represented is minus one times minus one. The block detects that case explicitly and replaces it with the largest positive value.

Each operation reports saturation as a one-hot set request on `flag_set`, and a status register elsewhere ORs that request in. Which bit is raised depends on the operation:
- an operation that feeds accumulator n raises bit 16+n;
- a standalone 16-bit product raises bit 21;
- a precision reduction raises bit 22.

An operation is presented with `in_valid`. Its result and flag request appear together one clock later.

Top module: `frac_sat_mul`

## Requirements
- R1: While `rst_n` is low, and after reset before any operation, `out_valid`, `result` and `flag_set` are all zero.
- R2: `out_valid` equals `in_valid` delayed by exactly one clock. `flag_set` has at most one bit set, is zero whenever `out_valid` is low, and `result` keeps its last value while `out_valid` is low.
- R3: Mode 3'd0 (wide Q15) takes `op_a[15:0]` and `op_b[15:0]`, both Q15. It returns twice their signed product in `result[31:0]`, with `result[63:32]` zero. When both operands are 16'h8000, the result is 32'h7FFFFFFF and `flag_set` bit 16+`acc_sel` is raised.
- R4: Mode 3'd1 (wide Q31) returns twice the signed product of `op_a` and `op_b` as 64 bits. When both operands are 32'h80000000, the result is 64'h7FFFFFFFFFFFFFFF and bit 16+`acc_sel` is raised.
- R5: Mode 3'd2 (Q15 high half) returns bits [31:16] of the doubled Q15 product, zero-extended. When both operands are 16'h8000 it returns 16'h7FFF and raises bit 21, whatever `acc_sel` holds.
- R6: Mode 3'd3 (rounded Q15) adds 32'h8000 to the doubled Q15 product and returns bits [31:16] of the sum. When both operands are 16'h8000 it returns 16'h7FFF and raises bit 21.
- R7: Mode 3'd4 multiplies `op_a[7:0]` by `op_b[15:0]` as unsigned numbers. A product above 16'hFFFF is clamped to 16'hFFFF and raises bit 21.
- R8: Mode 3'd5 rounds the signed 32-bit `op_a` to 16 bits by adding 32'h8000 and taking bits [31:16]. A value at or above 32'h7FFF8000 yields 16'h7FFF and raises bit 22.
- R9: Mode 3'd6 reduces the signed 16-bit `op_a[15:0]` to an unsigned byte. A negative input gives 8'h00 and raises bit 22. A 15-bit magnitude above 15'h7F80 gives 8'hFF and raises bit 22. Any other input gives the magnitude shifted right by 7.
- R10: Mode 3'd7 returns the unsigned 16-bit product of `op_a[7:0]` and `op_b[7:0]` and never raises a flag.
- R11: Operand bits above those a mode uses do not affect its result, and `acc_sel` affects only the flag bit chosen in modes 3'd0 and 3'd1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| mode | input | 3 | Operation select (encodings in R3 to R10) |
| acc_sel | input | 2 | Accumulator index for flag selection |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| out_valid | output | 1 | Result and flag request valid |
| result | output | 64 | Product or reduced value, zero-extended |
| flag_set | output | 32 | One-hot saturation set request |

## Verification
The bench targets the minus-one-times-minus-one trap in every fractional mode:
- A design that only doubles the product wraps to the most negative value in the wide modes.
- A design that rounds after trapping overflows to 16'h8000 in the rounded mode.

Several boundaries are checked precisely:
- The rounding threshold 32'h7FFF8000, where an off-by-one comparison lets the sum wrap to 16'h8000.
- The byte reduction edge 15'h7F80 against 15'h7F81.
- Negative inputs to the byte reduction.

Flag routing is checked by moving `acc_sel` across modes: a wrong bit index or an accumulator index leaking into the 16-bit modes shows up as the wrong one-hot bit.

// File: rtl/fmul_pkg.sv
`timescale 1ns/1ps
package fmul_pkg;

  localparam int Q15_W = 16;
  localparam int Q31_W = 32;

  typedef enum logic [2:0] {
    MODE_Q15_WIDE  = 3'd0,
    MODE_Q31_WIDE  = 3'd1,
    MODE_Q15_HI    = 3'd2,
    MODE_Q15_RND   = 3'd3,
    MODE_U8_U16    = 3'd4,
    MODE_RND_32_16 = 3'd5,
    MODE_RED_S16U8 = 3'd6,
    MODE_U8_U8     = 3'd7
  } mode_e;

  typedef struct packed {
    logic        sat;
    logic [15:0] val;
  } sat16_t;

  typedef struct packed {
    logic       sat;
    logic [7:0] val;
  } sat8_t;

  // Narrow a doubled Q15 product to its upper half, optionally rounded.
  function automatic sat16_t q15_narrow(input logic [31:0] dbl,
                                        input logic        trap,
                                        input logic        rnd);
    sat16_t     r;
    logic [31:0] sum;
    sum = dbl + (rnd ? 32'h0000_8000 : 32'h0);
    r.sat = trap;
    r.val = trap ? 16'h7FFF : sum[31:16];
    return r;
  endfunction

  // Unsigned byte by halfword, clamped to 16 bits.
  function automatic sat16_t u8u16_clamp(input logic [7:0]  a,
                                         input logic [15:0] b);
    sat16_t     r;
    logic [23:0] p;
    p = {16'h0, a} * {8'h0, b};
    r.sat = |p[23:16];
    r.val = r.sat ? 16'hFFFF : p[15:0];
    return r;
  endfunction

  // Signed word rounded to signed halfword.
  function automatic sat16_t round_32_16(input logic [31:0] a);
    sat16_t     r;
    logic [31:0] sum;
    r.sat = ($signed(a) >= $signed(32'h7FFF_8000));
    sum   = a + 32'h0000_8000;
    r.val = r.sat ? 16'h7FFF : sum[31:16];
    return r;
  endfunction

  // Signed halfword reduced to unsigned byte.
  function automatic sat8_t reduce_s16_u8(input logic [15:0] a);
    sat8_t r;
    if (a[15]) begin
      r.sat = 1'b1;
      r.val = 8'h00;
    end else if (a[14:0] > 15'h7F80) begin
      r.sat = 1'b1;
      r.val = 8'hFF;
    end else begin
      r.sat = 1'b0;
      r.val = a[14:7];
    end
    return r;
  endfunction

endpackage

// File: rtl/fmul_frac_unit.sv
`timescale 1ns/1ps
module fmul_frac_unit #(
  parameter int W = 16
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] prod,
  output logic           trap
);
  localparam int PW = 2 * W;
  localparam logic [W-1:0]  MIN_OP  = {1'b1, {(W-1){1'b0}}};
  localparam logic [PW-1:0] MAX_RES = {1'b0, {(PW-1){1'b1}}};

  logic signed [PW-1:0] a_ext;
  logic signed [PW-1:0] b_ext;
  logic signed [PW-1:0] raw;
  logic        [PW-1:0] doubled;

  always_comb begin
    a_ext   = $signed({{W{a[W-1]}}, a});
    b_ext   = $signed({{W{b[W-1]}}, b});
    raw     = a_ext * b_ext;
    doubled = {raw[PW-2:0], 1'b0};
    trap    = (a == MIN_OP) && (b == MIN_OP);
    prod    = trap ? MAX_RES : doubled;
  end
endmodule

// File: rtl/fmul_int_unit.sv
`timescale 1ns/1ps
module fmul_int_unit
  import fmul_pkg::*;
(
  input  logic [7:0]  a8,
  input  logic [15:0] b16,
  output sat16_t      clamp16,
  output logic [15:0] plain16
);
  always_comb begin
    clamp16 = u8u16_clamp(a8, b16);
    plain16 = {8'h0, a8} * {8'h0, b16[7:0]};
  end
endmodule

// File: rtl/fmul_reduce_unit.sv
`timescale 1ns/1ps
module fmul_reduce_unit
  import fmul_pkg::*;
(
  input  logic [31:0] word_in,
  output sat16_t      half_out,
  output sat8_t       byte_out
);
  always_comb begin
    half_out = round_32_16(word_in);
    byte_out = reduce_s16_u8(word_in[15:0]);
  end
endmodule

// File: rtl/frac_sat_mul.sv
`timescale 1ns/1ps
module frac_sat_mul
  import fmul_pkg::*;
#(
  parameter int OP_W          = 32,
  parameter int NUM_ACC       = 4,
  parameter int FLAG_W        = 32,
  parameter int ACC_FLAG_BASE = 16,
  parameter int MUL_FLAG_BIT  = 21,
  parameter int RED_FLAG_BIT  = 22
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [2:0]                 mode,
  input  logic [$clog2(NUM_ACC)-1:0] acc_sel,
  input  logic [OP_W-1:0]            op_a,
  input  logic [OP_W-1:0]            op_b,
  output logic                       out_valid,
  output logic [2*OP_W-1:0]          result,
  output logic [FLAG_W-1:0]          flag_set
);
  localparam int HALF_W = OP_W / 2;
  localparam int RES_W  = 2 * OP_W;
  localparam int IDX_W  = $clog2(FLAG_W);

  // Named internal events, brought out for the assertions below.
  logic [2*HALF_W-1:0] q15_prod;
  logic                q15_trap;
  logic [RES_W-1:0]    q31_prod;
  logic                q31_trap;
  sat16_t              q15_hi;
  sat16_t              q15_rnd;
  sat16_t              int_clamp;
  logic [15:0]         int_plain;
  sat16_t              red_half;
  sat8_t               red_byte;

  logic [RES_W-1:0]    res_next;
  logic                sat_next;
  logic [IDX_W-1:0]    idx_next;
  logic [FLAG_W-1:0]   flag_next;

  fmul_frac_unit #(.W(HALF_W)) u_q15 (
    .a(op_a[HALF_W-1:0]), .b(op_b[HALF_W-1:0]), .prod(q15_prod), .trap(q15_trap)
  );

  fmul_frac_unit #(.W(OP_W)) u_q31 (
    .a(op_a), .b(op_b), .prod(q31_prod), .trap(q31_trap)
  );

  fmul_int_unit u_int (
    .a8(op_a[7:0]), .b16(op_b[15:0]), .clamp16(int_clamp), .plain16(int_plain)
  );

  fmul_reduce_unit u_red (
    .word_in(op_a), .half_out(red_half), .byte_out(red_byte)
  );

  always_comb begin
    q15_hi  = q15_narrow(q15_prod, q15_trap, 1'b0);
    q15_rnd = q15_narrow(q15_prod, q15_trap, 1'b1);
  end

  // Result and flag selection by mode.
  always_comb begin
    res_next = '0;
    sat_next = 1'b0;
    idx_next = IDX_W'(MUL_FLAG_BIT);
    case (mode_e'(mode))
      MODE_Q15_WIDE: begin
        res_next = RES_W'(q15_prod);
        sat_next = q15_trap;
        idx_next = IDX_W'(ACC_FLAG_BASE) + IDX_W'(acc_sel);
      end
      MODE_Q31_WIDE: begin
        res_next = q31_prod;
        sat_next = q31_trap;
        idx_next = IDX_W'(ACC_FLAG_BASE) + IDX_W'(acc_sel);
      end
      MODE_Q15_HI: begin
        res_next = RES_W'(q15_hi.val);
        sat_next = q15_hi.sat;
      end
      MODE_Q15_RND: begin
        res_next = RES_W'(q15_rnd.val);
        sat_next = q15_rnd.sat;
      end
      MODE_U8_U16: begin
        res_next = RES_W'(int_clamp.val);
        sat_next = int_clamp.sat;
      end
      MODE_RND_32_16: begin
        res_next = RES_W'(red_half.val);
        sat_next = red_half.sat;
        idx_next = IDX_W'(RED_FLAG_BIT);
      end
      MODE_RED_S16U8: begin
        res_next = RES_W'(red_byte.val);
        sat_next = red_byte.sat;
        idx_next = IDX_W'(RED_FLAG_BIT);
      end
      default: begin
        res_next = RES_W'(int_plain);
        sat_next = 1'b0;
      end
    endcase
  end

  // One-hot set request, one comparator per status bit.
  generate
    for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
      assign flag_next[i] = in_valid && sat_next && (idx_next == IDX_W'(i));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      flag_set  <= '0;
    end else begin
      out_valid <= in_valid;
      flag_set  <= flag_next;
      if (in_valid) result <= res_next;
    end
  end

  // R2: output timing and flag shape
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result)));
  p_flag_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flag_set) && (out_valid || flag_set == '0));

  // R3: wide Q15 trap
  p_q15_trap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 3'd0 && op_a[15:0] == 16'h8000 && op_b[15:0] == 16'h8000)
    |=> (result == 64'h7FFF_FFFF && flag_set[ACC_FLAG_BASE + int'($past(acc_sel))]));

  // R4: wide Q31 trap
  p_q31_trap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 3'd1 && op_a == 32'h8000_0000 && op_b == 32'h8000_0000)
    |=> (result == 64'h7FFF_FFFF_FFFF_FFFF && flag_set[ACC_FLAG_BASE + int'($past(acc_sel))]));

  // R7: clamp bound
  p_clamp_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 3'd4) |=> (result <= 64'hFFFF));

  // R8: rounding threshold
  p_rnd_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 3'd5 && $signed(op_a) >= $signed(32'h7FFF_8000))
    |=> (result == 64'h7FFF && flag_set[RED_FLAG_BIT]));

  // R9: negative input reduction
  p_red_neg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 3'd6 && op_a[15]) |=> (result == 64'h0 && flag_set[RED_FLAG_BIT]));

  // R10: plain product never flags
  p_plain_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 3'd7) |=> (flag_set == '0));
endmodule

// File: tb/sim_frac_sat_mul.sv
`timescale 1ns/1ps
module sim_frac_sat_mul;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [1:0]  acc_sel = 2'd0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        out_valid;
  logic [63:0] result;
  logic [31:0] flag_set;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  frac_sat_mul u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .acc_sel(acc_sel),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .result(result), .flag_set(flag_set)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] bit_at(input int n);
    return 32'd1 << n;
  endfunction

  // Issue one operation; outputs are read 1 ns after the capturing edge.
  task automatic run(input logic [2:0] m, input logic [1:0] acc,
                     input logic [31:0] a, input logic [31:0] b,
                     output logic [63:0] r, output logic [31:0] f);
    @(negedge clk);
    mode = m; acc_sel = acc; op_a = a; op_b = b; in_valid = 1'b1;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    if (out_valid !== 1'b1) begin
      checks++; errors++;
      $display("FAIL R2 out_valid actual=%b expected=1", out_valid);
    end
    r = result;
    f = flag_set;
  endtask

  // Bench model of a doubled Q15 product, as a 32-bit pattern.
  function automatic logic [31:0] ref_q15(input logic [15:0] a, input logic [15:0] b);
    longint p;
    if (a == 16'h8000 && b == 16'h8000) return 32'h7FFF_FFFF;
    p = longint'(shortint'(a)) * longint'(shortint'(b)) * 2;
    return p[31:0];
  endfunction

  task automatic t_reset();
    chk("R1 out_valid", {63'h0, out_valid}, 64'h0);
    chk("R1 result", result, 64'h0);
    chk("R1 flag_set", {32'h0, flag_set}, 64'h0);
  endtask

  task automatic t_q15_wide();
    logic [63:0] r; logic [31:0] f;
    run(3'd0, 2'd2, 32'hABCD_4000, 32'h5555_4000, r, f);
    chk("R3 half times half", r, {32'h0, ref_q15(16'h4000, 16'h4000)});
    chk("R3 no flag", {32'h0, f}, 64'h0);
    run(3'd0, 2'd0, 32'h0000_8000, 32'h0000_7FFF, r, f);
    chk("R3 neg product", r, 64'h0000_0000_8001_0000);
    run(3'd0, 2'd3, 32'h0000_8000, 32'hFFFF_8000, r, f);
    chk("R3 trap value", r, 64'h7FFF_FFFF);
    chk("R3 trap flag acc3", {32'h0, f}, {32'h0, bit_at(19)});
  endtask

  task automatic t_q31_wide();
    logic [63:0] r; logic [31:0] f;
    run(3'd1, 2'd1, 32'h8000_0000, 32'h8000_0000, r, f);
    chk("R4 trap value", r, 64'h7FFF_FFFF_FFFF_FFFF);
    chk("R4 trap flag acc1", {32'h0, f}, {32'h0, bit_at(17)});
    run(3'd1, 2'd1, 32'h4000_0000, 32'hC000_0000, r, f);
    chk("R4 quarter negative", r, 64'hE000_0000_0000_0000);
    chk("R4 no flag", {32'h0, f}, 64'h0);
  endtask

  task automatic t_q15_hi();
    logic [63:0] r; logic [31:0] f;
    run(3'd2, 2'd3, 32'h0000_6000, 32'h0000_6000, r, f);
    chk("R5 high half", r, {48'h0, ref_q15(16'h6000, 16'h6000) >> 16});
    run(3'd2, 2'd3, 32'h0000_8000, 32'h0000_8000, r, f);
    chk("R5 trap value", r, 64'h7FFF);
    chk("R5 R11 flag 21 despite acc", {32'h0, f}, {32'h0, bit_at(21)});
    run(3'd2, 2'd0, 32'h0000_0001, 32'h0000_4000, r, f);
    chk("R5 truncates", r, 64'h0);
  endtask

  task automatic t_q15_rnd();
    logic [63:0] r; logic [31:0] f;
    logic [31:0] s;
    run(3'd3, 2'd0, 32'h0000_0001, 32'h0000_4000, r, f);
    chk("R6 round up", r, 64'h1);
    s = ref_q15(16'h9000, 16'h3000) + 32'h8000;
    run(3'd3, 2'd0, 32'h0000_9000, 32'h0000_3000, r, f);
    chk("R6 negative rounded", r, {48'h0, s[31:16]});
    run(3'd3, 2'd2, 32'h0000_8000, 32'h0000_8000, r, f);
    chk("R6 trap value", r, 64'h7FFF);
    chk("R6 trap flag", {32'h0, f}, {32'h0, bit_at(21)});
  endtask

  task automatic t_u8u16();
    logic [63:0] r; logic [31:0] f;
    run(3'd4, 2'd0, 32'h1234_5610, 32'hFFFF_0FFF, r, f);
    chk("R7 R11 in range", r, 64'hFFF0);
    chk("R7 no flag", {32'h0, f}, 64'h0);
    run(3'd4, 2'd0, 32'h0000_00FF, 32'h0000_FFFF, r, f);
    chk("R7 clamp", r, 64'hFFFF);
    chk("R7 clamp flag", {32'h0, f}, {32'h0, bit_at(21)});
  endtask

  task automatic t_rnd32();
    logic [63:0] r; logic [31:0] f;
    run(3'd5, 2'd0, 32'h7FFF_8000, 32'h0, r, f);
    chk("R8 threshold value", r, 64'h7FFF);
    chk("R8 threshold flag", {32'h0, f}, {32'h0, bit_at(22)});
    run(3'd5, 2'd0, 32'h7FFF_7FFF, 32'h0, r, f);
    chk("R8 below threshold", r, 64'h7FFF);
    chk("R8 below no flag", {32'h0, f}, 64'h0);
    run(3'd5, 2'd0, 32'h1234_8000, 32'h0, r, f);
    chk("R8 half rounds up", r, 64'h1235);
    run(3'd5, 2'd0, 32'hFFFF_7FFF, 32'h0, r, f);
    chk("R8 negative", r, 64'hFFFF);
    run(3'd5, 2'd0, 32'h8000_0000, 32'h0, r, f);
    chk("R8 most negative", r, 64'h8000);
  endtask

  task automatic t_red8();
    logic [63:0] r; logic [31:0] f;
    run(3'd6, 2'd0, 32'h0000_8000, 32'h0, r, f);
    chk("R9 negative", r, 64'h0);
    chk("R9 negative flag", {32'h0, f}, {32'h0, bit_at(22)});
    run(3'd6, 2'd0, 32'h0000_7F81, 32'h0, r, f);
    chk("R9 above edge", r, 64'hFF);
    chk("R9 above edge flag", {32'h0, f}, {32'h0, bit_at(22)});
    run(3'd6, 2'd0, 32'h0000_7F80, 32'h0, r, f);
    chk("R9 at edge", r, 64'hFF);
    chk("R9 at edge no flag", {32'h0, f}, 64'h0);
    run(3'd6, 2'd0, 32'hFFFF_1234, 32'h0, r, f);
    chk("R9 R11 shift", r, 64'h24);
  endtask

  task automatic t_u8u8();
    logic [63:0] r; logic [31:0] f;
    run(3'd7, 2'd3, 32'h0000_FFFF, 32'h0000_FFFF, r, f);
    chk("R10 product", r, 64'hFE01);
    chk("R10 never flags", {32'h0, f}, 64'h0);
  endtask

  task automatic t_idle();
    logic [63:0] r; logic [31:0] f;
    run(3'd4, 2'd0, 32'hFF, 32'hFFFF, r, f);
    @(posedge clk);
    #1;
    chk("R2 idle valid", {63'h0, out_valid}, 64'h0);
    chk("R2 idle flag cleared", {32'h0, flag_set}, 64'h0);
    chk("R2 result held", result, 64'hFFFF);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    t_reset();
    t_q15_wide();
    t_q31_wide();
    t_q15_hi();
    t_q15_rnd();
    t_u8u16();
    t_rnd32();
    t_red8();
    t_u8u8();
    t_idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule